// File: doc/BRIEF.md
# Single-Bit Accumulator Processor Core

This core runs programs whose data is a single bit. It puts a 4-bit address on an external program memory and reads back a 3-bit word. The upper two bits of the word select the operation and the lowest bit is an immediate data operand. The core holds a program counter, a 3-bit instruction register, a 1-bit accumulator and a 1-bit output register. A 1-bit ALU computes AND or OR of the accumulator and the immediate bit. The result goes only to the output register, which drives the output pin.

Every instruction takes three phases, always in the same order. FETCH copies the memory word at the current address into the instruction register. BUMP adds one to the program counter, so the next word appears on the memory bus but is not captured yet. EXEC decodes the held word and performs it. The sequencer has three named states, PH_FETCH (code 0), PH_BUMP (code 1) and PH_EXEC (code 2). Its transitions are FETCH→BUMP, BUMP→EXEC and EXEC→FETCH, and each one is taken only on a clock edge where the phase strobe is high. Otherwise the sequencer stays in its state. The strobe comes from the `step_i` pin by default. A parameter can switch to an internal divider that raises the strobe every `STROBE_DIV` clocks.

Top module: `bitcore_top`

## Requirements
- R1: While reset is held and after it is released, the program counter is 0, the output is 0, the phase is PH_FETCH (code 0), and the register enables are low.
- R2: A strobe in PH_FETCH captures the word at the current address. A change to that memory location after the capture has no effect on the instruction that executes.
- R3: A strobe in PH_BUMP adds one to the program counter, and the counter wraps from 15 to 0. No other phase changes the program counter.
- R4: With the strobe low, the phase, the program counter and the output hold their values.
- R5: Opcode 01 (load) writes the data bit (word bit 0) into the accumulator, asserts the accumulator enable during EXEC, and leaves the output unchanged.
- R6: Opcode 10 (and) sets the operation select to 0, writes accumulator AND data bit to the output with the output enable asserted, and leaves the accumulator unchanged.
- R7: Opcode 11 (or) sets the operation select to 1 and writes accumulator OR data bit to the output with the output enable asserted.
- R8: Opcode 00 (no-op) changes neither the accumulator nor the output, whatever its data bit is.
- R9: The accumulator enable and the output enable are high only on a strobe cycle in PH_EXEC, and never both at once.
- R10: Strobes move the phase through FETCH→BUMP→EXEC→FETCH without end. The program "010, 101" leaves output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Phase-advance strobe (external strobe mode) |
| mem_word_i | input | 3 | Program word: bits 2:1 opcode, bit 0 data |
| mem_addr_o | output | PC_W | Program counter, used as memory address |
| out_o | output | 1 | Output register |
| phase_o | output | 2 | Current phase: 0 FETCH, 1 BUMP, 2 EXEC |
| acc_load_o | output | 1 | Accumulator write enable |
| out_load_o | output | 1 | Output register write enable |
| alu_sel_o | output | 1 | ALU operation select: 0 AND, 1 OR |

## Verification
Some rules are checked by assertions on every cycle: the phase order, holding state while the strobe is low, the program counter step, that the enables fire only in EXEC and never together, and that each enabled write lands in the right register while an ALU write leaves the accumulator alone. Only the bench scenarios can show the end-to-end results. These are the output value after each opcode and data combination, that a no-op with data 1 does not touch the accumulator, that changing memory after FETCH is ignored, and that the address wraps after sixteen instructions.

// File: rtl/bitcore_pkg.sv
package bitcore_pkg;
    localparam int WORD_W = 3;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_BUMP  = 2'd1,
        PH_EXEC  = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_LDA = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } opcode_t;

    typedef struct packed {
        logic acc_we;
        logic out_we;
        logic alu_sel;
    } ctrl_t;
endpackage

// File: rtl/bitcore_strobe.sv
module bitcore_strobe #(
    parameter bit EXT_STROBE = 1'b1,
    parameter int STROBE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_step,
    output logic step
);
    localparam int CNT_W = (STROBE_DIV > 1) ? $clog2(STROBE_DIV) : 1;

    generate
        if (EXT_STROBE) begin : g_ext
            assign step = ext_step;
        end else begin : g_int
            logic [CNT_W-1:0] cnt_q;
            logic             tick;
            logic             unused_ext;
            assign unused_ext = ext_step;
            assign tick = (cnt_q == CNT_W'(STROBE_DIV - 1));
            always_ff @(posedge clk) begin
                if (!rst_n)    cnt_q <= '0;
                else if (tick) cnt_q <= '0;
                else           cnt_q <= cnt_q + 1'b1;
            end
            assign step = tick;
        end
    endgenerate
endmodule

// File: rtl/bitcore_seq.sv
module bitcore_seq
    import bitcore_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    output phase_t phase,
    output logic   fetch_en,
    output logic   bump_en,
    output logic   exec_en
);
    phase_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FETCH: if (step) state_d = PH_BUMP;
            PH_BUMP:  if (step) state_d = PH_EXEC;
            PH_EXEC:  if (step) state_d = PH_FETCH;
            default:  state_d = PH_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_FETCH;
        else        state_q <= state_d;
    end

    // per-phase action strobes
    always_comb begin
        fetch_en = 1'b0;
        bump_en  = 1'b0;
        exec_en  = 1'b0;
        unique case (state_q)
            PH_FETCH: fetch_en = step;
            PH_BUMP:  bump_en  = step;
            PH_EXEC:  exec_en  = step;
            default:  ;
        endcase
    end

    assign phase = state_q;

    assert_fetch_to_bump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && step) |=> phase == PH_BUMP);
    assert_bump_to_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BUMP && step) |=> phase == PH_EXEC);
    assert_exec_to_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && step) |=> phase == PH_FETCH);
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(phase));
endmodule

// File: rtl/bitcore_ctrl.sv
module bitcore_ctrl
    import bitcore_pkg::*;
(
    input  logic    exec_en,
    input  opcode_t opcode,
    output ctrl_t   ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OP_NOP: ;
            OP_LDA: ctrl.acc_we = exec_en;
            OP_AND: begin
                ctrl.alu_sel = 1'b0;
                ctrl.out_we  = exec_en;
            end
            OP_OR: begin
                ctrl.alu_sel = 1'b1;
                ctrl.out_we  = exec_en;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitcore_alu.sv
module bitcore_alu (
    input  logic a,
    input  logic b,
    input  logic sel,
    output logic y
);
    always_comb begin
        unique case (sel)
            1'b0: y = a & b;
            1'b1: y = a | b;
            default: y = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitcore_dp.sv
module bitcore_dp
    import bitcore_pkg::*;
#(
    parameter int PC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic              bump_en,
    input  ctrl_t             ctrl,
    input  logic [WORD_W-1:0] mem_word,
    output logic [PC_W-1:0]   pc,
    output opcode_t           opcode,
    output logic              out_bit
);
    logic [WORD_W-1:0] ir_q;
    logic              acc_q;
    logic              alu_y;
    logic              data_bit;

    assign data_bit = ir_q[0];
    assign opcode   = opcode_t'(ir_q[WORD_W-1:1]);

    bitcore_alu u_alu (
        .a   (acc_q),
        .b   (data_bit),
        .sel (ctrl.alu_sel),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            ir_q    <= '0;
            acc_q   <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            if (fetch_en)    ir_q    <= mem_word;
            if (bump_en)     pc      <= pc + 1'b1;
            if (ctrl.acc_we) acc_q   <= data_bit;
            if (ctrl.out_we) out_bit <= alu_y;
        end
    end

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bump_en |=> pc == PC_W'($past(pc) + 1'b1));
    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bump_en |=> $stable(pc));
    assert_acc_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.acc_we |=> acc_q == $past(data_bit));
    assert_acc_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.acc_we |=> $stable(acc_q));
    assert_out_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.out_we |=> out_bit == $past(alu_y));
    assert_out_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.out_we |=> $stable(out_bit));
endmodule

// File: rtl/bitcore_top.sv
module bitcore_top
    import bitcore_pkg::*;
#(
    parameter int PC_W       = 4,
    parameter bit EXT_STROBE = 1'b1,
    parameter int STROBE_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [2:0]      mem_word_i,
    output logic [PC_W-1:0] mem_addr_o,
    output logic            out_o,
    output logic [1:0]      phase_o,
    output logic            acc_load_o,
    output logic            out_load_o,
    output logic            alu_sel_o
);
    logic    step;
    phase_t  phase;
    logic    fetch_en, bump_en, exec_en;
    opcode_t opcode;
    ctrl_t   ctrl;

    bitcore_strobe #(.EXT_STROBE(EXT_STROBE), .STROBE_DIV(STROBE_DIV)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_step (step_i),
        .step     (step)
    );

    bitcore_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .phase    (phase),
        .fetch_en (fetch_en),
        .bump_en  (bump_en),
        .exec_en  (exec_en)
    );

    bitcore_ctrl u_ctrl (
        .exec_en (exec_en),
        .opcode  (opcode),
        .ctrl    (ctrl)
    );

    bitcore_dp #(.PC_W(PC_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_en (fetch_en),
        .bump_en  (bump_en),
        .ctrl     (ctrl),
        .mem_word (mem_word_i),
        .pc       (mem_addr_o),
        .opcode   (opcode),
        .out_bit  (out_o)
    );

    assign phase_o    = phase;
    assign acc_load_o = ctrl.acc_we;
    assign out_load_o = ctrl.out_we;
    assign alu_sel_o  = ctrl.alu_sel;

    assert_enables_in_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.acc_we || ctrl.out_we) |-> (phase == PH_EXEC && step));
    assert_enables_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl.acc_we, ctrl.out_we}));
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(mem_addr_o) && $stable(out_o));
endmodule

// File: tb/tb_bitcore_top.sv
module tb_bitcore_top;
    typedef struct packed {
        logic       o;
        logic [3:0] a;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic [2:0] mem_word_i;
    logic [3:0] mem_addr_o;
    logic       out_o;
    logic [1:0] phase_o;
    logic       acc_load_o, out_load_o, alu_sel_o;

    logic [2:0] mem [16];
    sb_item_t   exp_q[$];
    event       exec_done;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;
    logic       acc_m = 1'b0, out_m = 1'b0;
    logic [3:0] pc_m = '0;

    always #5 clk = ~clk;

    always_comb mem_word_i = mem[mem_addr_o];

    bitcore_top dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .mem_word_i(mem_word_i),
        .mem_addr_o(mem_addr_o), .out_o(out_o), .phase_o(phase_o),
        .acc_load_o(acc_load_o), .out_load_o(out_load_o), .alu_sel_o(alu_sel_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one strobe cycle; e_acc/e_out/e_sel are the expected enables while the strobe is high
    task automatic strobe(input logic e_acc, input logic e_out, input logic e_sel, input bit chk_sel);
        @(negedge clk);
        step_i = 1'b1;
        #1;
        chk(acc_load_o == e_acc, "R9 acc enable", acc_load_o, e_acc);
        chk(out_load_o == e_out, "R9 out enable", out_load_o, e_out);
        if (chk_sel) chk(alu_sel_o == e_sel, "R6/R7 alu select", alu_sel_o, e_sel);
        @(negedge clk);
        step_i = 1'b0;
    endtask

    // driver: runs one instruction, pushes the expected result into the scoreboard
    task automatic run_instr(input bit mutate);
        logic [2:0] w;
        logic [1:0] op;
        w  = mem[pc_m];
        op = w[2:1];
        chk(mem_addr_o == pc_m, "R3 address", mem_addr_o, pc_m);
        chk(phase_o == 2'd0, "R10 phase fetch", phase_o, 0);
        strobe(1'b0, 1'b0, 1'b0, 1'b0);
        chk(phase_o == 2'd1, "R10 phase bump", phase_o, 1);
        chk(mem_addr_o == pc_m, "R3 no step in fetch", mem_addr_o, pc_m);
        if (mutate) mem[pc_m] = {w[2:1], ~w[0]};   // R2: change after capture
        strobe(1'b0, 1'b0, 1'b0, 1'b0);
        pc_m = pc_m + 1'b1;
        chk(phase_o == 2'd2, "R10 phase exec", phase_o, 2);
        chk(mem_addr_o == pc_m, "R3 increment", mem_addr_o, pc_m);
        strobe(op == 2'b01, op[1], op == 2'b11, op[1]);
        if (mutate) mem[pc_m - 1'b1] = w;
        unique case (op)
            2'b01: acc_m = w[0];
            2'b10: out_m = acc_m & w[0];
            2'b11: out_m = acc_m | w[0];
            default: ;
        endcase
        exp_q.push_back('{o: out_m, a: pc_m});
        -> exec_done;
    endtask

    // monitor: pops and compares as results appear
    initial begin
        forever begin
            @(exec_done);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 scoreboard empty", 0, 1);
            end else begin
                sb_item_t e;
                e = exp_q.pop_front();
                chk(out_o == e.o, "R5-R8 output", out_o, e.o);
                chk(mem_addr_o == e.a, "R3 address after exec", mem_addr_o, e.a);
                chk(phase_o == 2'd0, "R10 back to fetch", phase_o, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // program: address -> word {op[1:0], data}
        mem[0]  = 3'b010;  // load 0
        mem[1]  = 3'b101;  // and 1 -> 0 (R10 example)
        mem[2]  = 3'b011;  // load 1
        mem[3]  = 3'b101;  // and 1 -> 1 (R6)
        mem[4]  = 3'b100;  // and 0 -> 0
        mem[5]  = 3'b111;  // or 1 -> 1 (R7)
        mem[6]  = 3'b000;  // no-op, out stays 1 (R8)
        mem[7]  = 3'b010;  // load 0
        mem[8]  = 3'b110;  // or 0 -> 0
        mem[9]  = 3'b111;  // or 1 -> 1
        mem[10] = 3'b001;  // no-op with data 1 (R8)
        mem[11] = 3'b110;  // or 0 -> 0 proves acc still 0
        mem[12] = 3'b011;  // load 1, out stays 0 (R5)
        mem[13] = 3'b110;  // or 0 -> 1
        mem[14] = 3'b100;  // and 0 -> 0
        mem[15] = 3'b110;  // or 0 -> 1, acc kept by and (R6)

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_addr_o == 4'd0, "R1 pc", mem_addr_o, 0);
        chk(out_o == 1'b0, "R1 out", out_o, 0);
        chk(phase_o == 2'd0, "R1 phase", phase_o, 0);
        chk(!acc_load_o && !out_load_o, "R1 enables", {acc_load_o, out_load_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase_o == 2'd0 && mem_addr_o == 4'd0, "R1 after release", phase_o, 0);

        // first pass: covers the R10 example at addresses 0 and 1
        for (int i = 0; i < 16; i++) run_instr(1'b0);
        chk(mem_addr_o == 4'd0, "R3 wrap 15->0", mem_addr_o, 0);

        // R4: hold with the strobe low
        begin
            logic [3:0] a0;
            logic       o0;
            a0 = mem_addr_o;
            o0 = out_o;
            step_i = 1'b0;
            repeat (6) @(negedge clk);
            chk(mem_addr_o == a0, "R4 address hold", mem_addr_o, a0);
            chk(out_o == o0, "R4 output hold", out_o, o0);
            chk(phase_o == 2'd0, "R4 phase hold", phase_o, 0);
        end

        // second pass: R2 memory changed after capture at address 9
        for (int i = 0; i < 16; i++) run_instr(i == 9);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule